// File: doc/BRIEF.md
# Fast Gate-Block Protection Controller

This block sits between a carrier-based PWM generator and the four gate drivers of a single-phase H-bridge. Two comparator flags from an external high-pass-filtered grid-voltage detector, one for each polarity, and an overcurrent comparator flag can turn every gate off. The turn-off path from any flag to the gate outputs is combinational. It acts within the same clock cycle, well inside one 80 kHz switching period, and it leaves most of the under-3 µs disturbance-to-block budget to the analog detector.

A synchronised copy of each flag drives the block state. The bridge stays blocked until a programmable number of cycles has passed since the last synchronised trigger. It is then released only on a carrier period boundary, which the PWM generator signals with a one-cycle tick. The same gate-block therefore covers both a grid sag and the following recovery, because the detector flags either polarity of the voltage step. A per-leg interlock turns off both switches of any leg whose two switches are requested together. A saturating counter records how many times the block was entered.

Top module: `fast_gate_block`

## Requirements
- R1: While any of hpf_hi_i, hpf_lo_i or oc_i is high, gate_o is 4'b0000 and blocked_o is 1 in the same cycle, with no clock edge in between.
- R2: hpf_hi_i alone and hpf_lo_i alone each trigger the block, so the block covers disturbances of either polarity, both on a sag and on a recovery.
- R3: While rst_ni is low, and after it rises until the first clock edge that samples carrier_tick_i high, gate_o is 0, blocked_o is 1 and blk_cnt_o is 0.
- R4: A flag that is high on a clock edge sets the internal block state after SYNC_STAGES+1 edges, so blocked_o stays high after the flag drops.
- R5: Once blocked, the block releases only on an edge where carrier_tick_i is high, no synchronised trigger is present, and at least hold_cyc_i edges have passed since the last edge that saw a synchronised trigger.
- R6: gate_o bit 0/1 are the high/low switches of leg A, bits 2/3 those of leg B. If both bits of a leg are requested on pwm_req_i, both outputs of that leg are 0. The other leg is not affected.
- R7: When neither blocked nor triggered, each non-conflicting leg passes pwm_req_i to gate_o unchanged.
- R8: blk_cnt_o increments by one on each entry into the blocked state from the released state. A retrigger while already blocked does not increment it. It saturates at its maximum value and is cleared only by reset.
- R9: With hold_cyc_i = 0, the block releases on the first carrier tick after the synchronised trigger has cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| carrier_tick_i | input | 1 | One-cycle pulse at each carrier period boundary |
| hold_cyc_i | input | HOLD_W | Minimum hold time in clock cycles after the last trigger |
| hpf_hi_i | input | 1 | Filtered grid voltage above the positive threshold |
| hpf_lo_i | input | 1 | Filtered grid voltage below the negative threshold |
| oc_i | input | 1 | Overcurrent comparator flag |
| pwm_req_i | input | 4 | Gate requests {B low, B high, A low, A high} |
| gate_o | output | 4 | Gated switch commands, same bit order |
| blocked_o | output | 1 | Gate-block active |
| blk_cnt_o | output | CNT_W | Saturating count of block activations |

## Verification
The bench builds the block with HOLD_W = 4 and CNT_W = 3. A 3-bit counter reaches its saturation value of 7 after a modest number of trigger pulses, so the saturation boundary can be tested. The small hold width keeps every hold window short, so release on both the minimum-hold limit and the carrier-tick limit happens many times within a short run, including the zero-hold case. SYNC_STAGES keeps its default of 2, and the bench measures the three-edge latency from flag to block state against it.

// File: rtl/gb_pkg.sv
package gb_pkg;
  localparam int unsigned NUM_LEGS  = 2;
  localparam int unsigned NUM_SW    = 2 * NUM_LEGS;
  localparam int unsigned NUM_FLAGS = 3;

  typedef enum logic [1:0] {
    FLAG_HPF_HI = 2'd0,
    FLAG_HPF_LO = 2'd1,
    FLAG_OC     = 2'd2
  } flag_idx_e;
endpackage

// File: rtl/gb_sync.sv
module gb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/gb_leg_guard.sv
module gb_leg_guard (
  input  logic       kill_i,
  input  logic [1:0] req_i,
  output logic [1:0] gate_o
);
  logic conflict;

  assign conflict = req_i[0] & req_i[1];

  always_comb begin
    if (kill_i || conflict) gate_o = 2'b00;
    else                    gate_o = req_i;
  end
endmodule

// File: rtl/gb_hold_ctrl.sv
module gb_hold_ctrl #(
  parameter int unsigned HOLD_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_s_i,
  input  logic              tick_i,
  input  logic [HOLD_W-1:0] hold_cyc_i,
  output logic              blk_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic              blk_q;
  logic [HOLD_W-1:0] hold_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              hold_done;

  assign hold_done = (hold_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q  <= 1'b1;
      hold_q <= '0;
      cnt_q  <= '0;
    end else if (trig_s_i) begin
      blk_q  <= 1'b1;
      hold_q <= hold_cyc_i;
      if (!blk_q && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end else begin
      if (!hold_done) hold_q <= hold_q - 1'b1;
      // release only on a carrier boundary once hold has elapsed
      if (blk_q && hold_done && tick_i) blk_q <= 1'b0;
    end
  end

  assign blk_o = blk_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/fast_gate_block.sv
module fast_gate_block
  import gb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_W      = 16,
  parameter int unsigned CNT_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              carrier_tick_i,
  input  logic [HOLD_W-1:0] hold_cyc_i,
  input  logic              hpf_hi_i,
  input  logic              hpf_lo_i,
  input  logic              oc_i,
  input  logic [3:0]        pwm_req_i,
  output logic [3:0]        gate_o,
  output logic              blocked_o,
  output logic [CNT_W-1:0]  blk_cnt_o
);
  logic [NUM_FLAGS-1:0] flags_raw;
  logic [NUM_FLAGS-1:0] flags_s;
  logic                 trig_raw;
  logic                 trig_s;
  logic                 blk_q;
  logic                 kill;

  assign flags_raw[FLAG_HPF_HI] = hpf_hi_i;
  assign flags_raw[FLAG_HPF_LO] = hpf_lo_i;
  assign flags_raw[FLAG_OC]     = oc_i;

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_sync
    gb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (flags_raw[f]),
      .q_o    (flags_s[f])
    );
  end

  assign trig_raw = |flags_raw;
  assign trig_s   = |flags_s;

  gb_hold_ctrl #(.HOLD_W(HOLD_W), .CNT_W(CNT_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_s_i   (trig_s),
    .tick_i     (carrier_tick_i),
    .hold_cyc_i (hold_cyc_i),
    .blk_o      (blk_q),
    .cnt_o      (blk_cnt_o)
  );

  // asynchronous kill path: raw flags bypass the synchronisers
  assign kill = trig_raw | blk_q;

  for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
    gb_leg_guard u_guard (
      .kill_i (kill),
      .req_i  (pwm_req_i[2*l+1:2*l]),
      .gate_o (gate_o[2*l+1:2*l])
    );
  end

  assign blocked_o = kill;
endmodule

// File: rtl/fast_gate_block_chk.sv
module fast_gate_block_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             carrier_tick_i,
  input logic             hpf_hi_i,
  input logic             hpf_lo_i,
  input logic             oc_i,
  input logic [3:0]       pwm_req_i,
  input logic [3:0]       gate_o,
  input logic             blocked_o,
  input logic             blk_q,
  input logic [CNT_W-1:0] blk_cnt_o
);
  assert_kill_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hpf_hi_i || hpf_lo_i || oc_i) |-> (gate_o == 4'b0000 && blocked_o));

  assert_leg_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o[0] && gate_o[1]) && !(gate_o[2] && gate_o[3]));

  assert_no_spurious_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o & ~pwm_req_i) == 4'b0000);

  assert_release_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(blk_q) |-> $past(carrier_tick_i));

  assert_cnt_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ({1'b0, blk_cnt_o} == {1'b0, $past(blk_cnt_o)} ||
              {1'b0, blk_cnt_o} == {1'b0, $past(blk_cnt_o)} + 1'b1));
endmodule

bind fast_gate_block fast_gate_block_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .carrier_tick_i (carrier_tick_i),
  .hpf_hi_i       (hpf_hi_i),
  .hpf_lo_i       (hpf_lo_i),
  .oc_i           (oc_i),
  .pwm_req_i      (pwm_req_i),
  .gate_o         (gate_o),
  .blocked_o      (blocked_o),
  .blk_q          (blk_q),
  .blk_cnt_o      (blk_cnt_o)
);

// File: tb/sim_fast_gate_block.sv
module sim_fast_gate_block;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD_W     = 4;
  localparam int CNT_W      = 3;
  localparam int CAR_LEN    = 8;
  localparam int CNT_MAX    = (1 << CNT_W) - 1;

  logic              clk;
  logic              rst_n;
  logic              tick;
  logic [HOLD_W-1:0] hold;
  logic              hi, lo, oc;
  logic [3:0]        req;
  logic [3:0]        gate;
  logic              blocked;
  logic [CNT_W-1:0]  cnt;

  fast_gate_block #(.SYNC_STAGES(2), .HOLD_W(HOLD_W), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .carrier_tick_i(tick), .hold_cyc_i(hold),
    .hpf_hi_i(hi), .hpf_lo_i(lo), .oc_i(oc), .pwm_req_i(req),
    .gate_o(gate), .blocked_o(blocked), .blk_cnt_o(cnt)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;
  string cur_req = "R3";

  // behavioural reference
  bit m_blk = 1;
  int m_hold = 0;
  int m_cnt = 0;
  bit m_s1 = 0, m_s2 = 0;

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string r, input int got, input int exp, input string what);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d (cycle %0d)", r, what, got, exp, cyc);
    end
  endtask

  function automatic logic [1:0] leg_exp(input logic [1:0] r, input bit k);
    if (k || (r == 2'b11)) return 2'b00;
    return r;
  endfunction

  task automatic step();
    bit raw, kill, tr;
    logic [3:0] eg;
    string gr;
    tick = ((cyc % CAR_LEN) == CAR_LEN - 1);
    #(CLK_PERIOD/4);
    raw  = hi | lo | oc;
    kill = raw | m_blk | !rst_n;
    eg   = {leg_exp(req[3:2], kill), leg_exp(req[1:0], kill)};
    gr   = raw ? "R1" : ((req[1:0] == 2'b11 || req[3:2] == 2'b11) ? "R6" : cur_req);
    chk(gr, gate, eg, "gate_o");
    chk(cur_req, blocked, kill, "blocked_o");
    chk("R8", cnt, m_cnt, "blk_cnt_o");
    @(posedge clk);
    if (!rst_n) begin
      m_blk = 1; m_hold = 0; m_cnt = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      tr = m_s2;
      if (tr) begin
        if (!m_blk && m_cnt < CNT_MAX) m_cnt++;
        m_blk = 1; m_hold = hold;
      end else begin
        if (m_blk && m_hold == 0 && tick) m_blk = 0;
        if (m_hold != 0) m_hold--;
      end
      m_s2 = m_s1;
      m_s1 = raw;
    end
    @(negedge clk);
    cyc++;
    req = 4'((cyc * 7 + 3) % 16);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse(input int which, input int len);
    for (int i = 0; i < len; i++) begin
      hi = (which == 0); lo = (which == 1); oc = (which == 2);
      step();
    end
    hi = 0; lo = 0; oc = 0;
  endtask

  initial begin
    rst_n = 0; tick = 0; hold = 4'd5; hi = 0; lo = 0; oc = 0; req = 4'b0101;
    @(negedge clk);
    cur_req = "R3"; idle(3);
    rst_n = 1;
    idle(CAR_LEN);                     // R3: held until first tick
    cur_req = "R7"; idle(20);          // R7/R6 pass-through and interlock
    cur_req = "R2"; pulse(0, 3);       // positive-polarity disturbance
    cur_req = "R5"; idle(30);
    cur_req = "R2"; pulse(1, 2);       // negative-polarity disturbance
    cur_req = "R4"; idle(30);
    cur_req = "R1"; pulse(2, 1);       // overcurrent
    cur_req = "R5"; idle(30);
    cur_req = "R8"; pulse(0, 1); idle(4); pulse(2, 1); idle(30); // retrigger
    hold = 4'd0;
    cur_req = "R9"; pulse(1, 1); idle(20);
    hold = 4'd15;
    cur_req = "R5"; pulse(2, 1); idle(40);
    hold = 4'd2;
    cur_req = "R8";
    for (int k = 0; k < 8; k++) begin pulse(2, 1); idle(20); end
    total++;
    if (cnt != 3'(CNT_MAX)) begin
      bad++;
      $display("FAIL R8 saturation got=%0d exp=%0d", cnt, CNT_MAX);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired got=%0d exp=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule